// File: doc/BRIEF.md
# Rational-Ratio Quadrature Table Oscillator

This block produces a sampled sine and cosine pair at a tone frequency that is a rational fraction of the sample rate. The fraction is expressed as a stride over a table length. One complete cycle of each waveform is stored at equally spaced phase points. A read index moves forward by the stride on every enabled sample and wraps modulo the table length. Because the stride and the length are coprime integers, the index never has to jump back to zero, and the output phase has no seam.

With the default setting the table has 171 points and the stride is 40. At an 855 kHz sample rate this gives a 200 kHz quadrature tone, which suits a digital downconverter that mixes a bandpass-sampled IF to baseband. A sample-enable strobe paces the oscillator. Each strobe yields one registered sine/cosine pair and a valid flag one clock later.

Top module: `ratio_quad_osc`

## Requirements
- R1: After reset the valid output is low and both sample outputs are zero. The first enabled sample after reset is phase point 0: sine 0 and cosine 2^(W-1)-1 (32767 for W=16).
- R2: The sample read at phase point n is sine = round(sin(2πn/L)·(2^(W-1)-1)) and cosine = round(cos(2πn/L)·(2^(W-1)-1)), with rounding half away from zero, as W-bit two's complement words.
- R3: Each enabled sample moves the phase point forward by S modulo L. With L=171 and S=40, the points visited from reset are 0, 40, 80, 120, 160, 29, 69, 109, 149, 18.
- R4: On a clock where the enable is low the phase point does not move. The next enabled sample continues from the point where the sequence paused.
- R5: The valid output is high exactly on the clock after a clock with the enable high, and low otherwise.
- R6: Sine and cosine come from the same phase point on the same clock. For every valid sample, sin²+cos² lies within 2·(2^(W-1)-1)+2 of (2^(W-1)-1)².
- R7: After L consecutive enabled samples the output sequence repeats exactly, with no discontinuity at the wrap.
- R8: While the valid output is low, the sine and cosine outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe: one output pair per high clock |
| sin_o | output | OUT_W | Sine sample, signed Q1.(W-1) |
| cos_o | output | OUT_W | Cosine sample, signed Q1.(W-1) |
| vld_o | output | 1 | Sample pair valid |

## Verification
A strobe sampled high at clock edge k makes vld_o, sin_o and cos_o show that phase point's pair after edge k. The phase point then advances for the strobe at edge k+1. The bench drives the strobe on the falling edge, updates its reference model after the next rising edge, and compares the outputs at the following falling edge, one register stage after the stimulus. The random strobe pattern tests pausing and hold. A directed run of 342 back-to-back samples compares each sample with the one taken L samples earlier.

// File: rtl/osc_pkg.sv
package osc_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Round half away from zero after scaling to just below full scale.
    function automatic int quantize(input real x, input int width);
        real full;
        real v;
        int  r;
        full = real'((1 << (width - 1)) - 1);
        v    = x * full;
        if (v >= 0.0)
            r = $rtoi(v + 0.5);
        else
            r = -$rtoi(0.5 - v);
        return r;
    endfunction

    function automatic int sin_point(input int n, input int len, input int width);
        return quantize($sin(TWO_PI * real'(n) / real'(len)), width);
    endfunction

    function automatic int cos_point(input int n, input int len, input int width);
        return quantize($cos(TWO_PI * real'(n) / real'(len)), width);
    endfunction

endpackage

// File: rtl/ratio_stepper.sv
module ratio_stepper #(
    parameter int TBL_LEN = 171,
    parameter int STRIDE  = 40,
    localparam int IDX_W  = $clog2(TBL_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } step_s;

    step_s         st_d, st_q;
    logic [IDX_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.idx} + (IDX_W+1)'(STRIDE);
        if (adv) begin
            if (sum >= (IDX_W+1)'(TBL_LEN))
                st_d.idx = IDX_W'(sum - (IDX_W+1)'(TBL_LEN));
            else
                st_d.idx = IDX_W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idx = st_q.idx;

    // Index always lies inside the table
    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.idx) < TBL_LEN);

    // Forward distance after an enabled sample equals the stride
    assert_stride_R3: assert property (@(posedge clk) disable iff (rst)
        adv |=> ((int'(st_q.idx) - int'($past(st_q.idx)) + TBL_LEN) % TBL_LEN) == STRIDE);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(st_q.idx));

endmodule

// File: rtl/quad_table.sv
module quad_table #(
    parameter int TBL_LEN = 171,
    parameter int OUT_W   = 16,
    localparam int IDX_W  = $clog2(TBL_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd,
    input  logic [IDX_W-1:0]        idx,
    output logic signed [OUT_W-1:0] sin_v,
    output logic signed [OUT_W-1:0] cos_v,
    output logic                    vld
);

    localparam longint FS  = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint FS2 = FS * FS;
    localparam longint TOL = 2 * FS + 2;

    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } rd_s;

    logic signed [OUT_W-1:0] sin_tab [TBL_LEN];
    logic signed [OUT_W-1:0] cos_tab [TBL_LEN];

    for (genvar n = 0; n < TBL_LEN; n++) begin : g_pt
        localparam int SV = osc_pkg::sin_point(n, TBL_LEN, OUT_W);
        localparam int CV = osc_pkg::cos_point(n, TBL_LEN, OUT_W);
        assign sin_tab[n] = SV[OUT_W-1:0];
        assign cos_tab[n] = CV[OUT_W-1:0];
    end

    rd_s rd_d, rd_q;

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = rd;
        if (rd) begin
            rd_d.s = sin_tab[idx];
            rd_d.c = cos_tab[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign sin_v = rd_q.s;
    assign cos_v = rd_q.c;
    assign vld   = rd_q.vld;

    assert_vld_follow_R5: assert property (@(posedge clk) disable iff (rst)
        rd |=> rd_q.vld);

    assert_vld_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rd_q.vld);

    assert_hold_out_R8: assert property (@(posedge clk) disable iff (rst)
        !rd |=> ($stable(rd_q.s) && $stable(rd_q.c)));

    // Pair taken from one phase point lies on the unit circle
    assert_quadrature_R6: assert property (@(posedge clk) disable iff (rst)
        rd_q.vld |-> (((longint'(rd_q.s) * rd_q.s + longint'(rd_q.c) * rd_q.c - FS2) <= TOL)
                   && ((longint'(rd_q.s) * rd_q.s + longint'(rd_q.c) * rd_q.c - FS2) >= -TOL)));

endmodule

// File: rtl/ratio_quad_osc.sv
module ratio_quad_osc #(
    parameter int TBL_LEN = 171,
    parameter int STRIDE  = 40,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_en,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    vld_o
);

    localparam int IDX_W = $clog2(TBL_LEN);

    logic [IDX_W-1:0] cur_idx;

    ratio_stepper #(
        .TBL_LEN (TBL_LEN),
        .STRIDE  (STRIDE)
    ) u_step (
        .clk (clk),
        .rst (rst),
        .adv (smp_en),
        .idx (cur_idx)
    );

    quad_table #(
        .TBL_LEN (TBL_LEN),
        .OUT_W   (OUT_W)
    ) u_tab (
        .clk   (clk),
        .rst   (rst),
        .rd    (smp_en),
        .idx   (cur_idx),
        .sin_v (sin_o),
        .cos_v (cos_o),
        .vld   (vld_o)
    );

    // First pair after reset comes from phase point zero
    assert_first_point_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && smp_en) |=> (sin_o == '0 && cos_o == OUT_W'((1 << (OUT_W - 1)) - 1)));

endmodule

// File: tb/tb_ratio_quad_osc.sv
`timescale 1ns/1ps
module tb_ratio_quad_osc;

    localparam int L  = 171;
    localparam int S  = 40;
    localparam int W  = 16;
    localparam int FS = (1 << (W - 1)) - 1;
    localparam real PI2 = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic signed [W-1:0] sin_o, cos_o;
    logic vld_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int m_idx = 0;
    bit m_vld = 0;
    int m_s = 0;
    int m_c = 0;

    int rec_s [2*L];
    int rec_c [2*L];

    ratio_quad_osc #(.TBL_LEN(L), .STRIDE(S), .OUT_W(W)) dut (
        .clk(clk), .rst(rst), .smp_en(en),
        .sin_o(sin_o), .cos_o(cos_o), .vld_o(vld_o)
    );

    always #2 clk = ~clk;

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic int exp_sin(input int n);
        return rnd($sin(PI2 * n / L) * FS);
    endfunction

    function automatic int exp_cos(input int n);
        return rnd($cos(PI2 * n / L) * FS);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_idx = 0; m_vld = 0; m_s = 0; m_c = 0;
        chk("R1 vld after reset", int'(vld_o), 0);
        chk("R1 sin after reset", int'(sin_o), 0);
        chk("R1 cos after reset", int'(cos_o), 0);
    endtask

    // Drive enable at a falling edge, compare one clock later.
    task automatic tick(input bit e);
        longint q;
        en = e;
        @(posedge clk);
        if (e) begin
            m_vld = 1; m_s = exp_sin(m_idx); m_c = exp_cos(m_idx);
            m_idx = (m_idx + S) % L;
        end else begin
            m_vld = 0;
        end
        @(negedge clk);
        chk("R5 valid", int'(vld_o), int'(m_vld));
        if (m_vld) begin
            chk("R2 R3 R4 sine", int'(sin_o), m_s);
            chk("R2 R3 R4 cosine", int'(cos_o), m_c);
            q = longint'(sin_o) * sin_o + longint'(cos_o) * cos_o - longint'(FS) * FS;
            chk("R6 quadrature", int'(q <= 2*FS+2 && q >= -(2*FS+2)), 1);
        end else begin
            chk("R8 sine hold", int'(sin_o), m_s);
            chk("R8 cosine hold", int'(cos_o), m_c);
        end
    endtask

    initial begin
        int seq [10] = '{0, 40, 80, 120, 160, 29, 69, 109, 149, 18};
        void'($urandom(32'd20250611));
        do_reset();

        // R1 first sample and R3 explicit sequence
        for (int i = 0; i < 10; i++) begin
            tick(1'b1);
            chk("R3 sequence sine", int'(sin_o), exp_sin(seq[i]));
            chk("R3 sequence cosine", int'(cos_o), exp_cos(seq[i]));
            if (i == 0) begin
                chk("R1 first sine", int'(sin_o), 0);
                chk("R1 first cosine", int'(cos_o), FS);
            end
        end

        // R4 pause then resume
        repeat (5) tick(1'b0);
        tick(1'b1);
        chk("R4 resume point", int'(sin_o), exp_sin((10 * S) % L));

        // Random strobe pattern
        for (int i = 0; i < 2000; i++) tick(1'(($urandom % 100) < 60));

        // R7 period: two full cycles back to back from reset
        do_reset();
        for (int k = 0; k < 2*L; k++) begin
            tick(1'b1);
            rec_s[k] = int'(sin_o);
            rec_c[k] = int'(cos_o);
        end
        for (int k = 0; k < L; k++) begin
            chk("R7 period sine", rec_s[k+L], rec_s[k]);
            chk("R7 period cosine", rec_c[k+L], rec_c[k]);
        end
        chk("R7 wrap back to point 0", rec_c[L], FS);

        // Reset in mid run
        repeat (7) tick(1'b1);
        do_reset();
        tick(1'b1);
        chk("R1 restart cosine", int'(cos_o), FS);

        repeat (40) tick(1'($urandom % 2));

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule